// File: doc/BRIEF.md
# CRTC horizontal timing generator

This block produces the horizontal timing of a character-based CRT controller. A character-rate enable, `char_en`, advances a character counter. For every character the block produces a horizontal sync level, a display enable and a 14-bit refresh address. It also captures the refresh address at which the visible part of the line ends.

Four host-programmable values define a line: the last character position (line total), the number of displayed characters, the character at which sync begins, and the sync width in characters. A start-address pair sets the refresh address that each new line begins from. Vertical timing is handled elsewhere; the `line_vis` input tells the block whether the current scan line is inside the visible area.

The host sees a two-location port. Location 0 selects a register index on write and returns a fixed status byte on read. Location 1 writes the selected register and reads it back. Only a small window of indices can be read back.

Top module: `crtc_htiming`

## Requirements
- R1: When the character counter equals the sync-position register (index 2), a 4-bit width counter is cleared and sync is requested. In the same character, an active sync stays high only while the width counter differs from bits [3:0] of the width register (index 3), and the width counter then increments modulo 16. Sync is therefore high for exactly that many characters, and a width of 0 gives no pulse at all. Bits [7:4] of index 3 have no effect.
- R2: `disp_en` is the AND of `line_vis` and an internal character-visible flag. That flag drops in the character where the counter equals the displayed-count register (index 1).
- R3: In the character where the counter equals index 1, `eol_addr` captures the refresh address presented for that character.
- R4: `ref_addr` advances by one per character and wraps from 0x3FFF to 0x0000.
- R5: In the character where the counter equals the line-total register (index 0), the counter returns to 0 and the visible flag is set again. The next character then presents the refresh address {index 12 bits [5:0], index 13}.
- R6: `ph2_stb` pulses for one clock directly after each character edge. At that point `disp_en_p2` shows the display enable as it stands after the end-of-line update of that same character.
- R7: A read at location 1 returns the selected register only for indices 12 to 17. Any other index returns 0xFF, and a read at location 0 always returns 0xFF. `cpu_rdata` is registered, so it is valid one clock after the select is applied.
- R8: Synchronous active-high `rst` clears every counter, every register and every output, and sets the visible flag.
- R9: While `char_en` is low, `hsync`, `disp_en`, `disp_en_p2`, `ref_addr` and `eol_addr` hold, and `ph2_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | Host location: 0 = index/status, 1 = register data |
| cpu_wr | input | 1 | Host write strobe |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Registered host read data |
| char_en | input | 1 | Character-clock enable |
| line_vis | input | 1 | Current scan line is visible |
| hsync | output | 1 | Horizontal sync |
| disp_en | output | 1 | Display enable, first half of the character |
| disp_en_p2 | output | 1 | Display enable after end-of-line update |
| ref_addr | output | 14 | Refresh address of the current character |
| eol_addr | output | 14 | Refresh address captured at end of visible characters |
| ph2_stb | output | 1 | One-clock strobe after each character edge |

## Verification
The assertions take `char_en` to be a single-clock qualifier. They also take `line_vis` to be meaningful only in the clock where `char_en` is high, and they assume the timing registers are not rewritten while characters are being counted. The stimulus keeps to these conditions. It pulses `char_en` on every other clock and changes `line_vis` only together with `char_en`. It programs all registers while `char_en` is idle, which also lets the scoreboard model apply each new setting from a known character onward.

// File: rtl/crtc_h_pkg.sv
package crtc_h_pkg;
  localparam int DW      = 8;
  localparam int AW      = 14;
  localparam int NREG    = 18;
  localparam int IW      = $clog2(NREG + 1);
  localparam int IX_TOT  = 0;
  localparam int IX_DISP = 1;
  localparam int IX_SPOS = 2;
  localparam int IX_SWID = 3;
  localparam int IX_SAH  = 12;
  localparam int IX_SAL  = 13;
  localparam int RD_LO   = 12;
  localparam int RD_HI   = 17;

  function automatic logic readable(input logic [IW-1:0] idx);
    return (int'(idx) >= RD_LO) && (int'(idx) <= RD_HI);
  endfunction
endpackage

// File: rtl/crtc_hregs.sv
module crtc_hregs
  import crtc_h_pkg::*;
#(
  parameter int W  = DW,
  parameter int AWID = AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_sel,
  input  logic            cpu_wr,
  input  logic [W-1:0]    cpu_wdata,
  output logic [W-1:0]    cpu_rdata,
  output logic [W-1:0]    htotal,
  output logic [W-1:0]    hdisp,
  output logic [W-1:0]    hspos,
  output logic [3:0]      hswid,
  output logic [AWID-1:0] start_addr
);
  localparam int HIW = AWID - W;

  logic [IW-1:0] idx_q;
  logic [W-1:0]  regs_q [NREG];
  logic [W-1:0]  rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (cpu_wr && !cpu_sel) begin
      idx_q <= cpu_wdata[IW-1:0];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) regs_q[g] <= '0;
      else if (cpu_wr && cpu_sel && (int'(idx_q) == g)) regs_q[g] <= cpu_wdata;
    end
  end

  always_comb begin
    rd_mux = '1;
    if (cpu_sel && readable(idx_q)) rd_mux = regs_q[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_mux;
  end

  assign htotal     = regs_q[IX_TOT];
  assign hdisp      = regs_q[IX_DISP];
  assign hspos      = regs_q[IX_SPOS];
  assign hswid      = regs_q[IX_SWID][3:0];
  assign start_addr = {regs_q[IX_SAH][HIW-1:0], regs_q[IX_SAL]};

  p_status_r7: assert property (@(posedge clk) disable iff (rst)
    !cpu_sel |=> (cpu_rdata == '1));
  p_window_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && !readable(idx_q)) |=> (cpu_rdata == '1));
endmodule

// File: rtl/crtc_hchar.sv
module crtc_hchar
  import crtc_h_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] htotal,
  input  logic [W-1:0] hdisp,
  input  logic [W-1:0] hspos,
  output logic         hit_pos,
  output logic         hit_disp,
  output logic         hit_tot,
  output logic         vis_p1,
  output logic         vis_p2
);
  logic [W-1:0] cc_q;
  logic         vis_q;

  assign hit_pos  = (cc_q == hspos);
  assign hit_disp = (cc_q == hdisp);
  assign hit_tot  = (cc_q == htotal);
  assign vis_p1   = vis_q && !hit_disp;
  assign vis_p2   = hit_tot ? 1'b1 : vis_p1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q  <= '0;
      vis_q <= 1'b1;
    end else if (ce) begin
      cc_q  <= hit_tot ? '0 : cc_q + 1'b1;
      vis_q <= vis_p2;
    end
  end

  p_line_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && hit_tot) |=> (cc_q == '0) && vis_q);
  p_char_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(cc_q) && $stable(vis_q));
endmodule

// File: rtl/crtc_hsync.sv
module crtc_hsync #(
  parameter int SWW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           hit_pos,
  input  logic [SWW-1:0] width,
  output logic           hs
);
  logic [SWW-1:0] wc_q;
  logic [SWW-1:0] wc_a;
  logic           hs_a;
  logic           hs_n;
  logic [SWW-1:0] wc_n;

  always_comb begin
    hs_a = hit_pos || hs;
    wc_a = hit_pos ? '0 : wc_q;
    hs_n = hs_a && (wc_a != width);
    wc_n = hs_a ? wc_a + 1'b1 : wc_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs   <= 1'b0;
      wc_q <= '0;
    end else if (ce) begin
      hs   <= hs_n;
      wc_q <= wc_n;
    end
  end

  p_zero_width_r1: assert property (@(posedge clk) disable iff (rst)
    (ce && hit_pos && width == '0) |=> !hs);
  p_hs_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hs) |-> $past(ce && hit_pos));
endmodule

// File: rtl/crtc_haddr.sv
module crtc_haddr #(
  parameter int AWID = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic            hit_disp,
  input  logic            hit_tot,
  input  logic [AWID-1:0] start_addr,
  output logic [AWID-1:0] ra,
  output logic [AWID-1:0] eol_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ra       <= '0;
      eol_addr <= '0;
    end else if (ce) begin
      if (hit_disp) eol_addr <= ra;
      ra <= hit_tot ? start_addr : ra + 1'b1;
    end
  end

  p_ra_step_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && !hit_tot) |=> (ra == AWID'($past(ra) + 1'b1)));
  p_eol_latch_r3: assert property (@(posedge clk) disable iff (rst)
    (ce && hit_disp) |=> (eol_addr == $past(ra)));
endmodule

// File: rtl/crtc_htiming.sv
module crtc_htiming
  import crtc_h_pkg::*;
#(
  parameter int W    = DW,
  parameter int AWID = AW,
  parameter int SWW  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cpu_sel,
  input  logic            cpu_wr,
  input  logic [W-1:0]    cpu_wdata,
  output logic [W-1:0]    cpu_rdata,
  input  logic            char_en,
  input  logic            line_vis,
  output logic            hsync,
  output logic            disp_en,
  output logic            disp_en_p2,
  output logic [AWID-1:0] ref_addr,
  output logic [AWID-1:0] eol_addr,
  output logic            ph2_stb
);
  logic [W-1:0]    htotal, hdisp, hspos;
  logic [SWW-1:0]  hswid;
  logic [AWID-1:0] start_addr, ra;
  logic            hit_pos, hit_disp, hit_tot, vis_p1, vis_p2;

  crtc_hregs #(.W(W), .AWID(AWID)) u_regs (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .htotal(htotal),
    .hdisp(hdisp), .hspos(hspos), .hswid(hswid), .start_addr(start_addr)
  );

  crtc_hchar #(.W(W)) u_char (
    .clk(clk), .rst(rst), .ce(char_en), .htotal(htotal), .hdisp(hdisp),
    .hspos(hspos), .hit_pos(hit_pos), .hit_disp(hit_disp),
    .hit_tot(hit_tot), .vis_p1(vis_p1), .vis_p2(vis_p2)
  );

  crtc_hsync #(.SWW(SWW)) u_sync (
    .clk(clk), .rst(rst), .ce(char_en), .hit_pos(hit_pos),
    .width(hswid), .hs(hsync)
  );

  crtc_haddr #(.AWID(AWID)) u_addr (
    .clk(clk), .rst(rst), .ce(char_en), .hit_disp(hit_disp),
    .hit_tot(hit_tot), .start_addr(start_addr), .ra(ra), .eol_addr(eol_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_en    <= 1'b0;
      disp_en_p2 <= 1'b0;
      ref_addr   <= '0;
      ph2_stb    <= 1'b0;
    end else begin
      ph2_stb <= char_en;
      if (char_en) begin
        disp_en    <= vis_p1 && line_vis;
        disp_en_p2 <= vis_p2 && line_vis;
        ref_addr   <= ra;
      end
    end
  end

  p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    ph2_stb |-> $past(char_en));
  p_de_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (char_en && !line_vis) |=> !disp_en && !disp_en_p2);
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !char_en |=> $stable(ref_addr) && $stable(disp_en) && !ph2_stb);
endmodule

// File: tb/crtc_htiming_bench.sv
module crtc_htiming_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        char_en = 1'b0, line_vis = 1'b0;
  logic        hsync, disp_en, disp_en_p2, ph2_stb;
  logic [13:0] ref_addr, eol_addr;

  always #4 clk = ~clk;

  crtc_htiming u_crtc_htiming (
    .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .char_en(char_en),
    .line_vis(line_vis), .hsync(hsync), .disp_en(disp_en),
    .disp_en_p2(disp_en_p2), .ref_addr(ref_addr), .eol_addr(eol_addr),
    .ph2_stb(ph2_stb)
  );

  typedef struct packed {
    logic        hs;
    logic        de;
    logic        de2;
    logic [13:0] ra;
    logic [13:0] eol;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  sh [18];
  logic [7:0]  m_cc;
  logic        m_vis, m_hs;
  logic [3:0]  m_hsc;
  logic [13:0] m_ra, m_eol;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 18; i++) sh[i] = '0;
    m_cc = '0; m_vis = 1'b1; m_hs = 1'b0; m_hsc = '0; m_ra = '0; m_eol = '0;
  endtask

  task automatic wr_reg(input int idx, input logic [7:0] val);
    @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'(idx);
    @(negedge clk); cpu_sel = 1'b1; cpu_wdata = val;
    @(negedge clk); cpu_wr = 1'b0; cpu_sel = 1'b0;
    if (idx < 18) sh[idx] = val;
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] val);
    @(negedge clk); cpu_sel = 1'b0; cpu_wr = 1'b1; cpu_wdata = 8'(idx);
    @(negedge clk); cpu_wr = 1'b0; cpu_sel = 1'b1;
    @(negedge clk); val = cpu_rdata; cpu_sel = 1'b0;
  endtask

  // Driver: compute expected per character from R1..R5, then apply one char_en.
  task automatic run_chars(input int n, input logic lv);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      if (m_cc == sh[2]) begin m_hsc = '0; m_hs = 1'b1; end
      if (m_hs) begin m_hs = (m_hsc != sh[3][3:0]); m_hsc = m_hsc + 4'd1; end
      if (m_cc == sh[1]) begin m_vis = 1'b0; m_eol = m_ra; end
      e.de = m_vis & lv;
      e.ra = m_ra;
      m_ra = m_ra + 14'd1;
      if (m_cc == sh[0]) begin
        m_cc = '0; m_vis = 1'b1; m_ra = {sh[12][5:0], sh[13]};
      end else m_cc = m_cc + 8'd1;
      e.de2 = m_vis & lv;
      e.hs = m_hs;
      e.eol = m_eol;
      q.push_back(e);
      @(negedge clk); char_en = 1'b1; line_vis = lv;
      @(negedge clk); char_en = 1'b0;
    end
    @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && ph2_stb) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 strobe without expected item", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(hsync == e.hs, "R1 hsync", int'(hsync), int'(e.hs));
        chk(disp_en == e.de, "R2 disp_en", int'(disp_en), int'(e.de));
        chk(eol_addr == e.eol, "R3 eol_addr", int'(eol_addr), int'(e.eol));
        chk(ref_addr == e.ra, "R4/R5 ref_addr", int'(ref_addr), int'(e.ra));
        chk(disp_en_p2 == e.de2, "R6 disp_en_p2", int'(disp_en_p2), int'(e.de2));
      end
    end
  end

  int hs_cnt;
  always @(negedge clk) if (!rst && ph2_stb && hsync) hs_cnt++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [13:0] snap_ra, snap_eol;
    logic snap_hs, snap_de, snap_de2;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    chk(hsync == 0 && disp_en == 0 && disp_en_p2 == 0 && ph2_stb == 0, "R8 outputs",
        int'({hsync, disp_en, disp_en_p2, ph2_stb}), 0);
    chk(ref_addr == 0 && eol_addr == 0, "R8 addresses", int'(ref_addr), 0);
    rd_reg(14, v); chk(v == 8'h00, "R8 register cleared", int'(v), 0);

    // R7: readback window
    wr_reg(12, 8'h2A); rd_reg(12, v); chk(v == 8'h2A, "R7 read idx12", int'(v), 'h2A);
    wr_reg(17, 8'h5C); rd_reg(17, v); chk(v == 8'h5C, "R7 read idx17", int'(v), 'h5C);
    wr_reg(0, 8'h09);  rd_reg(0, v);  chk(v == 8'hFF, "R7 read idx0", int'(v), 'hFF);
    rd_reg(11, v); chk(v == 8'hFF, "R7 read idx11", int'(v), 'hFF);
    rd_reg(18, v); chk(v == 8'hFF, "R7 read idx18", int'(v), 'hFF);
    @(negedge clk); cpu_sel = 1'b0;
    @(negedge clk); chk(cpu_rdata == 8'hFF, "R7 status", int'(cpu_rdata), 'hFF);

    // R1..R6: basic line timing
    wr_reg(1, 8'd6); wr_reg(2, 8'd7); wr_reg(3, 8'h02);
    wr_reg(12, 8'h00); wr_reg(13, 8'h40);
    hs_cnt = 0;
    run_chars(30, 1'b1);
    chk(hs_cnt == 6, "R1 two-char pulses over three lines", hs_cnt, 6);
    run_chars(10, 1'b0);   // R2: line not visible

    // R1: width zero gives no pulse; upper bits of width ignored
    wr_reg(3, 8'h00); hs_cnt = 0;
    run_chars(20, 1'b1);
    chk(hs_cnt == 0, "R1 zero width", hs_cnt, 0);
    wr_reg(3, 8'hF3); hs_cnt = 0;
    run_chars(20, 1'b1);
    chk(hs_cnt == 6, "R1 width 3 with upper bits set", hs_cnt, 6);

    // R4: 14-bit wrap of refresh address
    wr_reg(0, 8'd7); wr_reg(1, 8'd5); wr_reg(2, 8'd3);
    wr_reg(12, 8'hFF); wr_reg(13, 8'hFC);
    run_chars(24, 1'b1);

    // R9: hold while char_en low
    snap_ra = ref_addr; snap_eol = eol_addr; snap_hs = hsync;
    snap_de = disp_en; snap_de2 = disp_en_p2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); line_vis = ~line_vis;
      chk(ph2_stb == 0, "R9 no strobe", int'(ph2_stb), 0);
    end
    chk(ref_addr == snap_ra && eol_addr == snap_eol, "R9 addresses held",
        int'(ref_addr), int'(snap_ra));
    chk(hsync == snap_hs && disp_en == snap_de && disp_en_p2 == snap_de2,
        "R9 levels held", int'({hsync, disp_en, disp_en_p2}),
        int'({snap_hs, snap_de, snap_de2}));
    line_vis = 1'b0;
    run_chars(8, 1'b1);
    chk(q.size() == 0, "R6 scoreboard drained", q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule